// File: doc/BRIEF.md
# Write-Once Byte Array Controller

This block controls a small write-once memory of 32 bytes. Two agents can program it: a CPU register port and a test/programming port. Each port offers a byte write and a lock request. The controller accepts at most one operation per cycle and enforces the write-once rules. Every rejected operation sets a sticky error flag, which software clears by pulsing a status-read strobe.

A byte freezes as soon as any of its bits holds a one. A byte that still holds only zeros can be programmed again, so a write of 0x00 leaves it open. A global lock bit can be set from either port. Once set, it stays set and blocks every later write. The two highest addresses hold identification data (a product code and a revision). Only the test port may program them, and it may do so only once. Reads are combinational and are always allowed. The storage is modelled as registers, with one used flag per byte.

Top module: `otp_ctrl`

## Requirements
- R1: After reset, every byte reads 0x00 with its used flag low, the lock is clear and the error flag is low.
- R2: An accepted write from either port to an open byte in an unlocked array stores the data at the next clock edge. The used flag goes high when the data has at least one bit set.
- R3: A write to a byte whose used flag is high is rejected. The byte keeps its value and the error flag is set.
- R4: A write of 0x00 to an open byte is accepted without error and leaves the byte open, so a later nonzero write is still accepted.
- R5: A lock request from either port on an unlocked array sets the lock. Only reset clears it.
- R6: While locked, every write and every lock request from either port is rejected. Contents stay unchanged and the error flag is set.
- R7: Addresses 30 and 31 are reserved. A CPU-port write to them is rejected with the error flag. A test-port write to them follows the normal once-only rule.
- R8: When both ports request an operation in the same cycle, the test port's operation is evaluated alone. The CPU port's operation is rejected, and the error flag is set.
- R9: The error flag stays high until a cycle in which the status-read strobe is high and no new rejection occurs. If a rejection and the strobe occur together, the flag stays high.
- R10: A port asserting both its lock request and its write enable in one cycle performs only the lock. The write is dropped without an error.
- R11: The read data and used flag follow the read address within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU port byte write request |
| cpu_lock | input | 1 | CPU port lock request |
| cpu_addr | input | 5 | CPU port byte address |
| cpu_data | input | 8 | CPU port write data |
| tst_wr | input | 1 | Test port byte write request |
| tst_lock | input | 1 | Test port lock request |
| tst_addr | input | 5 | Test port byte address |
| tst_data | input | 8 | Test port write data |
| stat_rd | input | 1 | Status-read strobe that clears the error flag |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Byte at the read address |
| rd_used | output | 1 | Used flag of the byte at the read address |
| err_flag | output | 1 | Sticky rejected-operation flag |
| locked | output | 1 | Global lock state |

## Verification
The writes come from each port on its own, from both ports in the same cycle (to different addresses and to the same address), and with lock and write raised together. Fresh bytes, frozen bytes, zero-data writes, reserved addresses and the locked state are all covered. This separates a rejection caused by the used flag from one caused by the reserved range, the lock or arbitration. The status strobe is applied in quiet cycles and in cycles that carry a rejection, which shows whether the clear or the set takes precedence.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PROG = 2'd1,
    OP_LOCK = 2'd2
  } otp_op_e;

  typedef enum logic {
    SRC_CPU = 1'b0,
    SRC_TST = 1'b1
  } otp_src_e;

  // lock outranks write inside one port
  function automatic otp_op_e decode_op(input logic wr, input logic lk);
    if (lk)      return OP_LOCK;
    else if (wr) return OP_PROG;
    else         return OP_IDLE;
  endfunction

endpackage

// File: rtl/otp_port_arb.sv
module otp_port_arb
  import otp_pkg::*;
#(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_lock,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          tst_wr,
  input  logic          tst_lock,
  input  logic [AW-1:0] tst_addr,
  input  logic [DW-1:0] tst_data,
  output otp_op_e       sel_op,
  output otp_src_e      sel_src,
  output logic [AW-1:0] sel_addr,
  output logic [DW-1:0] sel_data,
  output logic          cpu_bumped
);

  otp_op_e cpu_op;
  otp_op_e tst_op;

  always_comb begin
    cpu_op     = decode_op(cpu_wr, cpu_lock);
    tst_op     = decode_op(tst_wr, tst_lock);
    cpu_bumped = 1'b0;
    if (tst_op != OP_IDLE) begin
      sel_op     = tst_op;
      sel_src    = SRC_TST;
      sel_addr   = tst_addr;
      sel_data   = tst_data;
      cpu_bumped = (cpu_op != OP_IDLE);
    end else begin
      sel_op   = cpu_op;
      sel_src  = SRC_CPU;
      sel_addr = cpu_addr;
      sel_data = cpu_data;
    end
  end

  // R8: simultaneous requests hand the cycle to the test port
  a_r8_test_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((tst_wr || tst_lock) && (cpu_wr || cpu_lock)) |-> (sel_src == SRC_TST && cpu_bumped));

endmodule

// File: rtl/otp_guard.sv
module otp_guard
  import otp_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DEPTH  = 32,
  parameter int N_RSVD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  otp_op_e       op,
  input  otp_src_e      src,
  input  logic [AW-1:0] addr,
  input  logic          locked,
  input  logic          target_used,
  output logic          accept_prog,
  output logic          accept_lock,
  output logic          reject
);

  localparam logic [AW:0] RSVD_BASE = (AW+1)'(DEPTH - N_RSVD);

  logic rsvd_hit;

  always_comb begin
    rsvd_hit    = ({1'b0, addr} >= RSVD_BASE);
    accept_prog = 1'b0;
    accept_lock = 1'b0;
    reject      = 1'b0;
    unique case (op)
      OP_PROG: begin
        if (locked || target_used || (src == SRC_CPU && rsvd_hit)) reject = 1'b1;
        else                                                       accept_prog = 1'b1;
      end
      OP_LOCK: begin
        if (locked) reject = 1'b1;
        else        accept_lock = 1'b1;
      end
      default: ;
    endcase
  end

  // R7: the CPU never programs the identification bytes
  a_r7_cpu_rsvd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_PROG && src == SRC_CPU && addr >= AW'(DEPTH - N_RSVD)) |-> !accept_prog);

  // R6: nothing is accepted while the lock is set
  a_r6_locked_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !(accept_prog || accept_lock));

endmodule

// File: rtl/otp_cells.sv
module otp_cells #(
  parameter int AW    = 5,
  parameter int DW    = 8,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [DW-1:0] prog_data,
  input  logic          lock_set,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_used,
  output logic          tgt_used,
  output logic          locked
);

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [DEPTH-1:0]         used_q;
  logic [DEPTH-1:0]         byte_we;
  logic [DEPTH-1:0]         used_d;
  logic                     lock_q;
  logic                     lock_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    always_comb begin
      byte_we[i] = prog_en && (prog_addr == AW'(i));
      used_d[i]  = used_q[i] | (byte_we[i] & (|prog_data));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[i]  <= '0;
        used_q[i] <= 1'b0;
      end else if (byte_we[i]) begin
        mem_q[i]  <= prog_data;
        used_q[i] <= used_d[i];
      end
    end

    // R3: a byte holding a programmed bit never changes again
    a_r3_frozen_byte: assert property (@(posedge clk) disable iff (!rst_n)
      used_q[i] |=> $stable(mem_q[i]));
  end

  always_comb lock_d = lock_q | lock_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (lock_set) lock_q <= lock_d;
  end

  always_comb begin
    rd_data  = mem_q[rd_addr];
    rd_used  = used_q[rd_addr];
    tgt_used = used_q[prog_addr];
    locked   = lock_q;
  end

  // R5: the lock never falls while reset is released
  a_r5_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);

  // R6: a locked array keeps all contents
  a_r6_locked_contents: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(mem_q) && $stable(used_q)));

endmodule

// File: rtl/otp_ctrl.sv
module otp_ctrl
  import otp_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DW     = 8,
  parameter int N_RSVD = 2,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic          cpu_lock,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_data,
  input  logic          tst_wr,
  input  logic          tst_lock,
  input  logic [AW-1:0] tst_addr,
  input  logic [DW-1:0] tst_data,
  input  logic          stat_rd,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_used,
  output logic          err_flag,
  output logic          locked
);

  otp_op_e       sel_op;
  otp_src_e      sel_src;
  logic [AW-1:0] sel_addr;
  logic [DW-1:0] sel_data;
  logic          cpu_bumped;
  logic          accept_prog;
  logic          accept_lock;
  logic          guard_reject;
  logic          tgt_used;
  logic          any_reject;
  logic          err_q;
  logic          err_d;
  logic          err_en;

  otp_port_arb #(.AW(AW), .DW(DW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_lock   (cpu_lock),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .tst_wr     (tst_wr),
    .tst_lock   (tst_lock),
    .tst_addr   (tst_addr),
    .tst_data   (tst_data),
    .sel_op     (sel_op),
    .sel_src    (sel_src),
    .sel_addr   (sel_addr),
    .sel_data   (sel_data),
    .cpu_bumped (cpu_bumped)
  );

  otp_guard #(.AW(AW), .DEPTH(DEPTH), .N_RSVD(N_RSVD)) u_guard (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (sel_op),
    .src         (sel_src),
    .addr        (sel_addr),
    .locked      (locked),
    .target_used (tgt_used),
    .accept_prog (accept_prog),
    .accept_lock (accept_lock),
    .reject      (guard_reject)
  );

  otp_cells #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_cells (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_en   (accept_prog),
    .prog_addr (sel_addr),
    .prog_data (sel_data),
    .lock_set  (accept_lock),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .rd_used   (rd_used),
    .tgt_used  (tgt_used),
    .locked    (locked)
  );

  // sticky error: a new rejection outranks the clearing strobe
  always_comb begin
    any_reject = guard_reject | cpu_bumped;
    err_en     = any_reject | stat_rd;
    err_d      = any_reject;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  always_comb err_flag = err_q;

  // R9: every rejection leaves the flag raised
  a_r9_err_raised: assert property (@(posedge clk) disable iff (!rst_n)
    any_reject |=> err_flag);

  // R9: a quiet strobe clears the flag
  a_r9_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !any_reject) |=> !err_flag);

  // R2: accepted writes land in storage
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_prog && rd_addr == sel_addr && $stable(rd_addr)) |=> (rd_data == $past(sel_data)));

endmodule

// File: tb/sim_otp_ctrl.sv
module sim_otp_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_wr, cpu_lock, tst_wr, tst_lock, stat_rd;
  logic [4:0] cpu_addr, tst_addr, rd_addr;
  logic [7:0] cpu_data, tst_data, rd_data;
  logic       rd_used, err_flag, locked;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  otp_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_wr(cpu_wr), .cpu_lock(cpu_lock), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .tst_wr(tst_wr), .tst_lock(tst_lock), .tst_addr(tst_addr), .tst_data(tst_data),
    .stat_rd(stat_rd), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_used(rd_used), .err_flag(err_flag), .locked(locked)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       cw; logic cl; logic [4:0] ca; logic [7:0] cd;
    logic       tw; logic tl; logic [4:0] ta; logic [7:0] td;
    logic       sr;
    logic [4:0] ra;
    logic [7:0] ed; logic eu; logic ee; logic el;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd2, 1'b1,1'b0,5'd3,8'hA5,  1'b0,1'b0,5'd0,8'h00,  1'b0, 5'd3,8'hA5,1'b1,1'b0,1'b0}, // R2 cpu
    '{4'd2, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd5,8'h3C,  1'b0, 5'd5,8'h3C,1'b1,1'b0,1'b0}, // R2 test
    '{4'd3, 1'b1,1'b0,5'd3,8'hFF,  1'b0,1'b0,5'd0,8'h00,  1'b0, 5'd3,8'hA5,1'b1,1'b1,1'b0}, // R3
    '{4'd9, 1'b0,1'b0,5'd0,8'h00,  1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd3,8'hA5,1'b1,1'b0,1'b0}, // R9 clear
    '{4'd4, 1'b1,1'b0,5'd7,8'h00,  1'b0,1'b0,5'd0,8'h00,  1'b0, 5'd7,8'h00,1'b0,1'b0,1'b0}, // R4 zero
    '{4'd4, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd7,8'h81,  1'b0, 5'd7,8'h81,1'b1,1'b0,1'b0}, // R4 later
    '{4'd7, 1'b1,1'b0,5'd30,8'h11, 1'b0,1'b0,5'd0,8'h00,  1'b0, 5'd30,8'h00,1'b0,1'b1,1'b0}, // R7 cpu
    '{4'd7, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd30,8'h42, 1'b1, 5'd30,8'h42,1'b1,1'b0,1'b0}, // R7 test
    '{4'd7, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd31,8'h07, 1'b0, 5'd31,8'h07,1'b1,1'b0,1'b0}, // R7
    '{4'd3, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd31,8'h08, 1'b0, 5'd31,8'h07,1'b1,1'b1,1'b0}, // R3 rsvd
    '{4'd9, 1'b1,1'b0,5'd9,8'h55,  1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd9,8'h55,1'b1,1'b0,1'b0}, // R9
    '{4'd8, 1'b1,1'b0,5'd10,8'h11, 1'b1,1'b0,5'd11,8'h22, 1'b0, 5'd11,8'h22,1'b1,1'b1,1'b0}, // R8
    '{4'd8, 1'b0,1'b0,5'd0,8'h00,  1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd10,8'h00,1'b0,1'b0,1'b0}, // R8
    '{4'd8, 1'b1,1'b0,5'd12,8'hF0, 1'b1,1'b0,5'd12,8'h0F, 1'b0, 5'd12,8'h0F,1'b1,1'b1,1'b0}, // R8 same
    '{4'd10,1'b1,1'b1,5'd13,8'h66, 1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd13,8'h00,1'b0,1'b0,1'b1}, // R10
    '{4'd6, 1'b0,1'b0,5'd0,8'h00,  1'b1,1'b0,5'd14,8'h11, 1'b0, 5'd14,8'h00,1'b0,1'b1,1'b1}, // R6
    '{4'd9, 1'b1,1'b0,5'd15,8'h01, 1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd15,8'h00,1'b0,1'b1,1'b1}, // R9 set wins
    '{4'd5, 1'b0,1'b0,5'd0,8'h00,  1'b0,1'b0,5'd0,8'h00,  1'b1, 5'd3,8'hA5,1'b1,1'b0,1'b1}, // R5
    '{4'd6, 1'b0,1'b0,5'd0,8'h00,  1'b0,1'b1,5'd0,8'h00,  1'b0, 5'd5,8'h3C,1'b1,1'b1,1'b1}  // R6 lock
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    cpu_wr = 0; cpu_lock = 0; cpu_addr = 0; cpu_data = 0;
    tst_wr = 0; tst_lock = 0; tst_addr = 0; tst_data = 0;
    stat_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0;
    rd_addr = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;

    // R1: reset state over the whole array
    for (int a = 0; a < 32; a++) begin
      rd_addr = 5'(a);
      #1;
      chk($sformatf("R1 data[%0d]", a), rd_data, 8'h00);
      chk($sformatf("R1 used[%0d]", a), {7'd0, rd_used}, 8'h00);
    end
    chk("R1 err", {7'd0, err_flag}, 8'h00);
    chk("R1 lock", {7'd0, locked}, 8'h00);

    // vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cpu_wr = VEC[v].cw; cpu_lock = VEC[v].cl; cpu_addr = VEC[v].ca; cpu_data = VEC[v].cd;
      tst_wr = VEC[v].tw; tst_lock = VEC[v].tl; tst_addr = VEC[v].ta; tst_data = VEC[v].td;
      stat_rd = VEC[v].sr;
      @(posedge clk);
      #2;
      idle_inputs();
      rd_addr = VEC[v].ra;
      #1;
      chk($sformatf("R%0d vec%0d data", VEC[v].req, v), rd_data, VEC[v].ed);
      chk($sformatf("R%0d vec%0d used", VEC[v].req, v), {7'd0, rd_used}, {7'd0, VEC[v].eu});
      chk($sformatf("R%0d vec%0d err", VEC[v].req, v), {7'd0, err_flag}, {7'd0, VEC[v].ee});
      chk($sformatf("R%0d vec%0d lock", VEC[v].req, v), {7'd0, locked}, {7'd0, VEC[v].el});
    end

    // R11: reads follow the address with no clock edge
    @(negedge clk);
    rd_addr = 5'd9;  #1; chk("R11 read 9", rd_data, 8'h55);
    rd_addr = 5'd31; #1; chk("R11 read 31", rd_data, 8'h07);
    rd_addr = 5'd7;  #1; chk("R11 read 7", rd_data, 8'h81);

    // R5: lock from the test port on a fresh array
    do_reset();
    chk("R1 lock after reset", {7'd0, locked}, 8'h00);
    tst_lock = 1;
    @(posedge clk); #2; idle_inputs(); #1;
    chk("R5 test lock", {7'd0, locked}, 8'h01);
    chk("R5 no err", {7'd0, err_flag}, 8'h00);

    // R6: cpu lock on a locked array is refused
    @(negedge clk);
    cpu_lock = 1;
    @(posedge clk); #2; idle_inputs(); #1;
    chk("R6 relock err", {7'd0, err_flag}, 8'h01);
    chk("R5 lock kept", {7'd0, locked}, 8'h01);

    // R8: test lock beats a cpu write in the same cycle
    do_reset();
    tst_lock = 1;
    cpu_wr = 1; cpu_addr = 5'd2; cpu_data = 8'h5A;
    @(posedge clk); #2; idle_inputs();
    rd_addr = 5'd2; #1;
    chk("R8 lock taken", {7'd0, locked}, 8'h01);
    chk("R8 cpu bumped err", {7'd0, err_flag}, 8'h01);
    chk("R8 cpu byte untouched", rd_data, 8'h00);

    // R9: flag holds without strobe
    repeat (3) @(negedge clk);
    chk("R9 flag held", {7'd0, err_flag}, 8'h01);

    finish_run();
  end

endmodule